// File: doc/BRIEF.md
# Recursive Sine Oscillator

This block produces a sampled sinusoid from a second-order digital resonator. Every new sample is the frequency coefficient times the latest sample, minus the sample before it. There is no phase accumulator and no lookup table. The coefficient is two times the cosine of the per-sample angle, 2·cos(2π·f·Ts). The frequency is therefore fixed by that one number. Amplitude and phase are fixed only by the two starting samples.

One multiplier and one adder are shared, and they are stepped through a fixed schedule of `CYC_PER_SAMPLE` clock cycles for each output sample. The subtraction is done by feeding the negated older sample into the adder port. A load pulse captures the coefficient and both starting samples and restarts the schedule. Each result is shifted down to a signed DAC word and saturated, then presented with a one-cycle valid strobe. A coefficient of zero with both starting samples at +1.0 gives a four-sample square-like pattern.

Top module: `recur_sine_osc`

## Requirements
- R1: Each new sample equals floor(coef · latest / 2^30) − older. The coefficient is signed Q2.30 in 32 bits. States are signed Q4.28 in 32 bits. The result is kept to 32 bits.
- R2: While `load` is sampled high, `coef_a`, `init_prev` (older sample) and `init_last` (latest sample) are captured and the schedule restarts. The first `sample_valid` is high in the cycle after the `CYC_PER_SAMPLE`-th rising edge that follows the last edge sampling `load` high.
- R3: While running, `sample_valid` is high for exactly one cycle in every `CYC_PER_SAMPLE` cycles. It is never high during a cycle that follows an edge with `load` high.
- R4: After each sample, the older state takes the latest value and the latest state takes the new sample. The second sample is therefore coef·first − `init_last`.
- R5: `sample_out` is the new state shifted right arithmetically by 13 bits (28 − 15) and clamped to [−32768, 32767]. A state of +1.0 gives 32767 and −1.0 gives −32768.
- R6: With coef = 0 and both initial states at +1.0, the outputs repeat −32768, −32768, 32767, 32767.
- R7: `sample_out` changes only in cycles where `sample_valid` is high. It keeps its value between samples and through a reload.
- R8: After reset, `sample_valid` and `sample_out` are 0, and no sample appears until the first load.
- R9: A load while the oscillator is running discards the sequence in progress and restarts from the newly captured values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Capture coefficient and initial states, restart schedule |
| coef_a | input | COEF_W | Frequency coefficient, signed Q2.30 |
| init_prev | input | STATE_W | Older initial sample, signed Q4.28 |
| init_last | input | STATE_W | Latest initial sample, signed Q4.28 |
| sample_out | output | DAC_W | Saturated signed DAC sample |
| sample_valid | output | 1 | One-cycle strobe marking a new sample |

## Verification
A sample is due exactly `CYC_PER_SAMPLE` rising edges after the last edge that samples `load` high, and every `CYC_PER_SAMPLE` edges after that. The bench counts falling edges from the load. It expects the strobe, and the value from its own arithmetic model, only on the edge where that count reaches `CYC_PER_SAMPLE`. In the earlier cycles it requires the strobe to be low and the output to be unchanged. A held load and a reload part-way through a sample restart this count.

// File: rtl/osc_pkg.sv
package osc_pkg;
  // pipeline depth of the shared multiply-add, in clock cycles
  localparam int MAC_LAT = 2;

  // smallest schedule that lets the multiply-add finish before the state update
  localparam int MIN_CYCLES = MAC_LAT + 1;
endpackage

// File: rtl/osc_sequencer.sv
module osc_sequencer #(
  parameter int CYC_PER_SAMPLE = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic running,
  output logic step
);
  localparam int PH_W = (CYC_PER_SAMPLE > 1) ? $clog2(CYC_PER_SAMPLE) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CYC_PER_SAMPLE - 1);

  logic [PH_W-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      phase   <= '0;
    end else if (load) begin
      running <= 1'b1;
      phase   <= '0;
    end else if (running) begin
      phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
    end
  end

  // last phase of a sample period: the multiply-add result is settled
  assign step = running && !load && (phase == PH_LAST);
endmodule

// File: rtl/osc_mac.sv
module osc_mac #(
  parameter int COEF_W    = 32,
  parameter int COEF_FRAC = 30,
  parameter int STATE_W   = 32
) (
  input  logic                      clk,
  input  logic signed [COEF_W-1:0]  coef,
  input  logic signed [STATE_W-1:0] mul_in,
  input  logic signed [STATE_W-1:0] add_in,
  output logic signed [STATE_W-1:0] result
);
  localparam int PROD_W = COEF_W + STATE_W;

  logic signed [PROD_W-1:0]  prod_q;
  logic signed [STATE_W-1:0] add_q;
  logic signed [PROD_W-1:0]  prod_scaled;

  // stage 1: product and addend
  always_ff @(posedge clk) begin
    prod_q <= PROD_W'(coef) * PROD_W'(mul_in);
    add_q  <= add_in;
  end

  assign prod_scaled = prod_q >>> COEF_FRAC;

  // stage 2: rescale and accumulate
  always_ff @(posedge clk) begin
    result <= prod_scaled[STATE_W-1:0] + add_q;
  end
endmodule

// File: rtl/osc_dac_sat.sv
module osc_dac_sat #(
  parameter int STATE_W    = 32,
  parameter int STATE_FRAC = 28,
  parameter int DAC_W      = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en,
  input  logic signed [STATE_W-1:0] state_in,
  output logic signed [DAC_W-1:0]   dac_out,
  output logic                      valid_out
);
  localparam int SHIFT = STATE_FRAC - (DAC_W - 1);
  localparam logic signed [STATE_W-1:0] MAXV = {{(STATE_W-DAC_W+1){1'b0}}, {(DAC_W-1){1'b1}}};
  localparam logic signed [STATE_W-1:0] MINV = {{(STATE_W-DAC_W+1){1'b1}}, {(DAC_W-1){1'b0}}};

  logic signed [STATE_W-1:0] scaled;
  logic signed [DAC_W-1:0]   clamped;

  assign scaled = state_in >>> SHIFT;

  always_comb begin
    if (scaled > MAXV)      clamped = MAXV[DAC_W-1:0];
    else if (scaled < MINV) clamped = MINV[DAC_W-1:0];
    else                    clamped = scaled[DAC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dac_out   <= '0;
      valid_out <= 1'b0;
    end else begin
      valid_out <= en;
      if (en) dac_out <= clamped;
    end
  end
endmodule

// File: rtl/recur_sine_osc.sv
module recur_sine_osc #(
  parameter int COEF_W         = 32,
  parameter int COEF_FRAC      = 30,
  parameter int STATE_W        = 32,
  parameter int STATE_FRAC     = 28,
  parameter int DAC_W          = 16,
  parameter int CYC_PER_SAMPLE = 5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load,
  input  logic signed [COEF_W-1:0]  coef_a,
  input  logic signed [STATE_W-1:0] init_prev,
  input  logic signed [STATE_W-1:0] init_last,
  output logic signed [DAC_W-1:0]   sample_out,
  output logic                      sample_valid
);
  logic                      running;
  logic                      step;
  logic signed [COEF_W-1:0]  coef_q;
  logic signed [STATE_W-1:0] x_old;
  logic signed [STATE_W-1:0] x_new;
  logic signed [STATE_W-1:0] x_neg;
  logic signed [STATE_W-1:0] mac_out;

  osc_sequencer #(.CYC_PER_SAMPLE(CYC_PER_SAMPLE)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .running (running),
    .step    (step)
  );

  // the older sample enters the adder negated, turning multiply-add into multiply-subtract
  assign x_neg = -x_old;

  osc_mac #(
    .COEF_W    (COEF_W),
    .COEF_FRAC (COEF_FRAC),
    .STATE_W   (STATE_W)
  ) u_mac (
    .clk    (clk),
    .coef   (coef_q),
    .mul_in (x_new),
    .add_in (x_neg),
    .result (mac_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      coef_q <= '0;
      x_old  <= '0;
      x_new  <= '0;
    end else if (load) begin
      coef_q <= coef_a;
      x_old  <= init_prev;
      x_new  <= init_last;
    end else if (step) begin
      x_old <= x_new;
      x_new <= mac_out;
    end
  end

  osc_dac_sat #(
    .STATE_W    (STATE_W),
    .STATE_FRAC (STATE_FRAC),
    .DAC_W      (DAC_W)
  ) u_dac (
    .clk       (clk),
    .rst       (rst),
    .en        (step),
    .state_in  (mac_out),
    .dac_out   (sample_out),
    .valid_out (sample_valid)
  );

  // unused in logic, kept for the schedule lower bound in the package
  localparam int SCHED_MIN = osc_pkg::MIN_CYCLES;
endmodule

// File: rtl/recur_sine_osc_checks.sv
module recur_sine_osc_checks #(
  parameter int DAC_W          = 16,
  parameter int CYC_PER_SAMPLE = 5
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    load,
  input logic signed [DAC_W-1:0] sample_out,
  input logic                    sample_valid
);
  localparam int CW = (CYC_PER_SAMPLE > 1) ? $clog2(CYC_PER_SAMPLE) : 1;
  localparam logic [CW-1:0] C_LAST = CW'(CYC_PER_SAMPLE - 1);

  logic          c_run;
  logic [CW-1:0] c_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      c_run <= 1'b0;
      c_cnt <= '0;
    end else if (load) begin
      c_run <= 1'b1;
      c_cnt <= '0;
    end else if (c_run) begin
      c_cnt <= (c_cnt == C_LAST) ? '0 : c_cnt + 1'b1;
    end
  end

  // R3: a strobe only closes a full schedule period
  p_valid_period_r3: assert property (@(posedge clk) disable iff (rst)
    sample_valid |-> $past(c_run && !load && (c_cnt == C_LAST)));

  // R3: strobe lasts one cycle
  p_valid_single_r3: assert property (@(posedge clk) disable iff (rst)
    sample_valid |=> !sample_valid);

  // R2: a load suppresses the strobe in the following cycle
  p_load_no_valid_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> !sample_valid);

  // R8: nothing is produced before the first load
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !c_run |-> !sample_valid);

  // R7: output holds between strobes
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !sample_valid |-> $stable(sample_out));
endmodule

bind recur_sine_osc recur_sine_osc_checks #(
  .DAC_W          (DAC_W),
  .CYC_PER_SAMPLE (CYC_PER_SAMPLE)
) u_checks (
  .clk          (clk),
  .rst          (rst),
  .load         (load),
  .sample_out   (sample_out),
  .sample_valid (sample_valid)
);

// File: tb/recur_sine_osc_bench.sv
module recur_sine_osc_bench;
  localparam int N     = 5;
  localparam int DAC_W = 16;
  localparam longint ONE = 64'sd1 <<< 28;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               load = 1'b0;
  logic signed [31:0] coef_a = '0;
  logic signed [31:0] init_prev = '0;
  logic signed [31:0] init_last = '0;
  logic signed [DAC_W-1:0] sample_out;
  logic               sample_valid;

  int checks = 0;
  int fails  = 0;

  longint m_coef, m_prev, m_last;
  longint held = 0;

  always #2.5 clk = ~clk;

  recur_sine_osc #(.CYC_PER_SAMPLE(N)) u_recur_sine_osc (
    .clk          (clk),
    .rst          (rst),
    .load         (load),
    .coef_a       (coef_a),
    .init_prev    (init_prev),
    .init_last    (init_last),
    .sample_out   (sample_out),
    .sample_valid (sample_valid)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint to_dac(input longint s);
    longint d;
    d = s >>> 13;
    if (d > 32767) d = 32767;
    if (d < -32768) d = -32768;
    return d;
  endfunction

  // model of the recurrence (R1) and state shift (R4)
  function automatic longint model_step();
    longint p, nx;
    p  = m_coef * m_last;
    nx = (p >>> 30) - m_prev;
    nx = longint'(int'(nx));
    m_prev = m_last;
    m_last = nx;
    return nx;
  endfunction

  // called at a negedge; load is sampled on `hold` edges
  task automatic do_load(input longint a, input longint p, input longint l, input int hold);
    coef_a    = 32'(a);
    init_prev = 32'(p);
    init_last = 32'(l);
    load      = 1'b1;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(sample_valid == 1'b0, "R3 no strobe under load", sample_valid, 0);
      chk(sample_out == held, "R7 hold through load", sample_out, held);
    end
    load = 1'b0;
    m_coef = a; m_prev = p; m_last = l;
  endtask

  task automatic run_samples(input int n, input string req);
    longint e;
    for (int s = 0; s < n; s++) begin
      for (int j = 1; j <= N; j++) begin
        @(negedge clk);
        if (j < N) begin
          chk(sample_valid == 1'b0, "R3 strobe low mid-period", sample_valid, 0);
          chk(sample_out == held, "R7 output held", sample_out, held);
        end else begin
          e = to_dac(model_step());
          chk(sample_valid == 1'b1, "R2 R3 strobe on schedule", sample_valid, 1);
          chk(sample_out == e, req, sample_out, e);
          held = e;
        end
      end
    end
  endtask

  initial begin
    real w;
    longint a, l;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk(sample_valid == 1'b0, "R8 reset strobe", sample_valid, 0);
    chk(sample_out == 0, "R8 reset output", sample_out, 0);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk(sample_valid == 1'b0, "R8 idle before load", sample_valid, 0);
    end

    // R6: square-like pattern
    do_load(0, ONE, ONE, 1);
    run_samples(8, "R6 square pattern");

    // R5: saturation both ways
    do_load(0, 0, 5 * ONE, 1);
    run_samples(4, "R5 saturate");
    do_load(0, ONE / 3, -ONE / 5, 1);
    run_samples(4, "R5 in-range scaling");

    // R1/R4: slow sine
    w = 2.0 * 3.14159265358979 * 0.03;
    a = longint'($rtoi(2.0 * $cos(w) * 1073741824.0));
    l = longint'($rtoi(0.9 * $sin(w) * 268435456.0));
    do_load(a, 0, l, 1);
    run_samples(60, "R1 R4 sine recurrence");

    // R1: faster tone, arbitrary phase, held load
    w = 2.0 * 3.14159265358979 * 0.2;
    a = longint'($rtoi(2.0 * $cos(w) * 1073741824.0));
    do_load(a, ONE / 2, -(ONE * 3) / 10, 6);
    run_samples(30, "R1 second tone");

    // R9: reload part-way through a period
    for (int j = 0; j < 2; j++) begin
      @(negedge clk);
      chk(sample_valid == 1'b0, "R9 pre-reload", sample_valid, 0);
    end
    do_load(-(64'sd1 <<< 29), ONE / 4, ONE / 2, 1);
    run_samples(12, "R9 restart after reload");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule